// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Priority Controller

This block gathers sixteen device interrupt request lines into a single active-low interrupt output for a processor. Two eight-line priority stages are used. The secondary stage handles lines 8 to 15 and has no interrupt path of its own. Its combined request enters the primary stage on input 2. As a result, the whole secondary group ranks directly behind primary lines 0 and 1 and ahead of primary lines 3 to 7. A device wired to the legacy line 2 is moved onto secondary input 1, so the controller serves it as line 9.

The processor sees the output fall and answers with a one-cycle acknowledge. On that cycle the controller resolves the winning line, loads its 8-bit vector into a single vector register and marks the line as in service. While a line is in service, requests of equal or lower priority are held back. A one-cycle end-of-service pulse releases the highest-priority line that is in service. A 16-bit mask register, loaded through a write strobe, keeps individual lines off the output and out of the vector.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: During and right after synchronous reset, `int_n` is 1, `vector` is 00h, the mask register is all zeros and no line is in service.
- R2: `int_n` is registered. It is 0 one clock after an unmasked request exists that outranks every line in service, and 1 one clock after no such request exists.
- R3: On acknowledge, a winning primary line p (0, 1, 3..7) loads vector 08h+p.
- R4: On acknowledge, a winning secondary line n (8..15) loads vector 70h+(n-8), so line 14 gives 76h.
- R5: The overall priority order, from highest to lowest, is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R6: A request on line 2 is treated as a request on line 9. It yields vector 71h and is gated by mask bit 9. Mask bit 2 has no effect.
- R7: Setting mask bit k (bit k of `mask_data`, written with `mask_wr`) stops line k from pulling `int_n` low or from winning an acknowledge.
- R8: An acknowledge puts the winner in service. Requests of equal or lower priority then cannot pull `int_n` low. Requests of higher priority, including a higher secondary line while a lower secondary line is in service, still can.
- R9: `eos` clears the highest-priority line in service. The cascade entry on primary input 2 stays in service until the last secondary line in service is cleared.
- R10: An acknowledge with no eligible request loads the spurious vector 0Fh and puts no line in service.
- R11: `vector` changes only on an acknowledge cycle and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Level request lines 0..15 |
| mask_wr | input | 1 | Loads `mask_data` into the mask register |
| mask_data | input | 16 | New mask; a 1 blocks the line |
| ack | input | 1 | One-cycle acknowledge from the processor |
| eos | input | 1 | One-cycle end-of-service pulse |
| int_n | output | 1 | Active-low interrupt to the processor |
| vector | output | 8 | Vector register read by the processor |

## Verification
A corrupted in-service bit shows up at `int_n` within two clocks. A stuck bit keeps a pending same-priority line quiet after end of service. A lost bit lets an equal or lower line pull the output low again right after the acknowledge. A wrong priority decision or a wrong cascade hand-off shows up in the vector one clock after the acknowledge. The nested scenarios are built so that each in-service layer is cleared in turn, with the output and vector checked between the pulses.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int STAGE_LINES = 8;
  localparam int VEC_BITS = 8;

  function automatic logic [VEC_BITS-1:0] make_vector(input logic [VEC_BITS-1:0] base,
                                                       input int unsigned idx);
    return base + VEC_BITS'(idx);
  endfunction
endpackage

// File: rtl/irq_prio_stage.sv
module irq_prio_stage #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  in_svc,
  input  logic [N-1:0]  pass_equal,
  output logic          any,
  output logic [IW-1:0] win
);
  logic [N-1:0] allowed;

  // A line is allowed while no line of higher priority is in service.
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    allowed = '0;
    for (int i = 0; i < N; i++) begin
      allowed[i] = !blocked && (!in_svc[i] || pass_equal[i]);
      if (in_svc[i]) blocked = 1'b1;
    end
  end

  // Lowest index wins.
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && allowed[i]) begin
        any = 1'b1;
        win = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int N = 8,
  parameter int CASC = 2,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_pri,
  input  logic [IW-1:0] set_pri_idx,
  input  logic          set_sec,
  input  logic [IW-1:0] set_sec_idx,
  input  logic          eos,
  output logic [N-1:0]  pri_q,
  output logic [N-1:0]  sec_q
);
  logic [N-1:0] pri_n, sec_n;

  always_comb begin
    logic found, sfound;
    pri_n  = pri_q;
    sec_n  = sec_q;
    found  = 1'b0;
    sfound = 1'b0;
    if (eos) begin
      for (int i = 0; i < N; i++) begin
        if (!found && pri_q[i]) begin
          found = 1'b1;
          if (i == CASC) begin
            for (int j = 0; j < N; j++) begin
              if (!sfound && sec_q[j]) begin
                sfound = 1'b1;
                sec_n[j] = 1'b0;
              end
            end
            if (sec_n == '0) pri_n[i] = 1'b0;
          end else begin
            pri_n[i] = 1'b0;
          end
        end
      end
    end
    if (set_pri) pri_n[set_pri_idx] = 1'b1;
    if (set_sec) sec_n[set_sec_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      pri_q <= pri_n;
      sec_q <= sec_n;
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int LINES = STAGE_LINES,
  parameter int VEC_W = VEC_BITS,
  parameter logic [VEC_W-1:0] PRI_BASE = 8'h08,
  parameter logic [VEC_W-1:0] SEC_BASE = 8'h70,
  parameter int CASC = 2,
  parameter int LEGACY_LINE = 2,
  parameter int REDIRECT_IN = 1,
  localparam int TOTAL = 2 * LINES,
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOTAL-1:0] irq_req,
  input  logic             mask_wr,
  input  logic [TOTAL-1:0] mask_data,
  input  logic             ack,
  input  logic             eos,
  output logic             int_n,
  output logic [VEC_W-1:0] vector
);
  localparam logic [VEC_W-1:0] SPUR_VEC = PRI_BASE + VEC_W'(LINES - 1);

  logic [TOTAL-1:0] mask_q;
  logic [LINES-1:0] sec_raw, sec_req, pri_req;
  logic [LINES-1:0] pri_isr, sec_isr;
  logic [LINES-1:0] pri_pass;
  logic             sec_any, pri_any, casc_win;
  logic [IW-1:0]    sec_win, pri_win;
  logic             mask_bit_unused;

  assign mask_bit_unused = mask_q[CASC];

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (mask_wr) mask_q <= mask_data;
  end

  // Legacy line folded onto the redirect input of the secondary stage.
  always_comb begin
    sec_raw = irq_req[TOTAL-1:LINES];
    sec_raw[REDIRECT_IN] = irq_req[LINES + REDIRECT_IN] | irq_req[LEGACY_LINE];
    sec_req = sec_raw & ~mask_q[TOTAL-1:LINES];
  end

  always_comb begin
    pri_req = irq_req[LINES-1:0] & ~mask_q[LINES-1:0];
    pri_req[CASC] = sec_any;
    pri_pass = '0;
    pri_pass[CASC] = 1'b1;
  end

  irq_prio_stage #(.N(LINES)) u_sec_stage (
    .req(sec_req), .in_svc(sec_isr), .pass_equal('0),
    .any(sec_any), .win(sec_win)
  );

  irq_prio_stage #(.N(LINES)) u_pri_stage (
    .req(pri_req), .in_svc(pri_isr), .pass_equal(pri_pass),
    .any(pri_any), .win(pri_win)
  );

  assign casc_win = pri_any && (pri_win == IW'(CASC));

  irq_inservice #(.N(LINES), .CASC(CASC)) u_isr (
    .clk(clk), .rst(rst),
    .set_pri(ack && pri_any), .set_pri_idx(pri_win),
    .set_sec(ack && casc_win), .set_sec_idx(sec_win),
    .eos(eos), .pri_q(pri_isr), .sec_q(sec_isr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n  <= 1'b1;
      vector <= '0;
    end else begin
      int_n <= ~pri_any;
      if (ack) begin
        if (casc_win)     vector <= make_vector(SEC_BASE, int'(sec_win));
        else if (pri_any) vector <= make_vector(PRI_BASE, int'(pri_win));
        else              vector <= SPUR_VEC;
      end
    end
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int N = 8,
  parameter logic [7:0] SPUR = 8'h0F,
  parameter logic [7:0] SEC_BASE = 8'h70
) (
  input logic         clk,
  input logic         rst,
  input logic         ack,
  input logic         int_n,
  input logic [7:0]   vector,
  input logic         pri_any,
  input logic         casc_win,
  input logic         casc_isr,
  input logic [N-1:0] sec_isr
);
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (int_n && vector == 8'h00));

  a_r2_int_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int_n == !$past(pri_any)));

  a_r11_vector_hold: assert property (@(posedge clk) disable iff (rst)
    !ack |=> $stable(vector));

  a_r10_spurious: assert property (@(posedge clk) disable iff (rst)
    (ack && !pri_any) |=> vector == SPUR);

  a_r4_sec_range: assert property (@(posedge clk) disable iff (rst)
    (ack && casc_win) |=> vector[7:3] == SEC_BASE[7:3]);

  a_r9_casc_track: assert property (@(posedge clk) disable iff (rst)
    (|sec_isr) == casc_isr);
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.N(LINES), .SPUR(SPUR_VEC), .SEC_BASE(SEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .int_n(int_n), .vector(vector),
  .pri_any(pri_any), .casc_win(casc_win), .casc_isr(pri_isr[CASC]), .sec_isr(sec_isr)
);

// File: tb/irq_cascade_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_req = '0;
  logic        mask_wr = 1'b0;
  logic [15:0] mask_data = '0;
  logic        ack = 1'b0;
  logic        eos = 1'b0;
  logic        int_n;
  logic [7:0]  vector;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req), .mask_wr(mask_wr),
    .mask_data(mask_data), .ack(ack), .eos(eos), .int_n(int_n), .vector(vector)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic do_eos();
    eos = 1'b1; tick(1); eos = 1'b0; tick(1);
  endtask

  task automatic set_mask(input logic [15:0] m);
    mask_data = m; mask_wr = 1'b1; tick(1); mask_wr = 1'b0; tick(1);
  endtask

  task automatic clean();
    irq_req = '0;
    set_mask('0);
    repeat (16) do_eos();
    tick(1);
  endtask

  task automatic t_reset();
    check("R1 int_n", {7'd0, int_n}, 8'd1);
    check("R1 vector", vector, 8'h00);
    irq_req[4] = 1'b1; tick(1);
    check("R1 mask clear", {7'd0, int_n}, 8'd0);
    clean();
  endtask

  task automatic t_primary();
    irq_req[5] = 1'b1; tick(1);
    check("R2 int low", {7'd0, int_n}, 8'd0);
    do_ack();
    check("R3 vec line5", vector, 8'h0D);
    tick(1);
    check("R8 same line held", {7'd0, int_n}, 8'd1);
    do_eos();
    check("R9 released", {7'd0, int_n}, 8'd0);
    irq_req[5] = 1'b0; tick(1);
    check("R2 int high", {7'd0, int_n}, 8'd1);
    clean();
  endtask

  task automatic t_secondary();
    irq_req[14] = 1'b1; tick(1);
    do_ack();
    check("R4 vec line14", vector, 8'h76);
    clean();
  endtask

  task automatic t_priority();
    irq_req[3] = 1'b1; irq_req[15] = 1'b1; tick(1);
    do_ack();
    check("R5 15 over 3", vector, 8'h77);
    clean();
    irq_req[0] = 1'b1; irq_req[8] = 1'b1; tick(1);
    do_ack();
    check("R5 0 over 8", vector, 8'h08);
    clean();
    irq_req[10] = 1'b1; irq_req[11] = 1'b1; irq_req[6] = 1'b1; tick(1);
    do_ack();
    check("R5 10 first", vector, 8'h72);
    clean();
  endtask

  task automatic t_legacy();
    irq_req[2] = 1'b1; tick(1);
    do_ack();
    check("R6 line2 as 9", vector, 8'h71);
    clean();
    set_mask(16'h0004);
    irq_req[2] = 1'b1; tick(1);
    check("R6 mask2 no effect", {7'd0, int_n}, 8'd0);
    set_mask(16'h0200);
    check("R6 mask9 gates line2", {7'd0, int_n}, 8'd1);
    clean();
  endtask

  task automatic t_mask();
    set_mask(16'h0010);
    irq_req[4] = 1'b1; irq_req[6] = 1'b1; tick(1);
    do_ack();
    check("R7 masked skipped", vector, 8'h0E);
    clean();
    set_mask(16'hFFFF);
    irq_req = 16'hFFFF; tick(2);
    check("R7 all masked", {7'd0, int_n}, 8'd1);
    clean();
  endtask

  task automatic t_nested();
    irq_req[12] = 1'b1; tick(1);
    do_ack();
    check("R4 vec line12", vector, 8'h74);
    tick(1);
    irq_req[13] = 1'b1; tick(1);
    check("R8 lower held", {7'd0, int_n}, 8'd1);
    irq_req[9] = 1'b1; tick(1);
    check("R8 higher passes", {7'd0, int_n}, 8'd0);
    do_ack();
    check("R8 nested vec", vector, 8'h71);
    irq_req[9] = 1'b0; tick(1);
    check("R8 all held", {7'd0, int_n}, 8'd1);
    do_eos();
    check("R9 cascade kept", {7'd0, int_n}, 8'd1);
    do_eos();
    check("R9 cascade freed", {7'd0, int_n}, 8'd0);
    do_ack();
    check("R9 line12 again", vector, 8'h74);
    clean();
    irq_req[3] = 1'b1; tick(1);
    do_ack();
    check("R3 vec line3", vector, 8'h0B);
    irq_req[10] = 1'b1; tick(2);
    check("R5 sec over 3", {7'd0, int_n}, 8'd0);
    do_ack();
    check("R5 sec vec", vector, 8'h72);
    clean();
  endtask

  task automatic t_spurious();
    do_ack();
    check("R10 spurious vec", vector, 8'h0F);
    tick(1);
    check("R10 int stays high", {7'd0, int_n}, 8'd1);
    irq_req[7] = 1'b1; tick(1);
    check("R10 nothing set", {7'd0, int_n}, 8'd0);
    clean();
  endtask

  task automatic t_hold();
    irq_req[1] = 1'b1; tick(1);
    do_ack();
    check("R3 vec line1", vector, 8'h09);
    irq_req = 16'h8001; tick(3);
    check("R11 vector held", vector, 8'h09);
    clean();
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_primary();
    t_secondary();
    t_priority();
    t_legacy();
    t_mask();
    t_nested();
    t_spurious();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule